// File: doc/BRIEF.md
# Biphase-Mark Audio Frame Encoder

This block turns a stereo pair of audio samples and their per-subframe validity, user and channel-status bits into a serial biphase-mark stream on a complementary output pair. Its output follows the two-channel subframe layout used by AES3 and S/PDIF. The block runs from one master clock at 128 times the sample rate, with one clock cycle per half-cell. A stereo frame therefore lasts 128 cycles: the left subframe comes first, then the right. Each subframe has 32 time slots. The block inserts the synchronisation preambles and computes even parity. It also tracks the frame's position inside the 192-frame channel-status block.

A sample buffer supplies the inputs. It watches `frame_sync_o` and holds the inputs for the next frame steady across the clock edge that raises that output. Samples narrower than 24 bits are placed left-justified, with zeros in the unused low bits. `block_o` marks the frames that carry the first 15 bytes of channel status. Both line outputs stay low while reset is held.

Top module: `bmc_frame_encoder`

## Requirements
- R1: While `rst_ni` is low, `tx_p_o`, `tx_n_o`, `block_o` and `frame_sync_o` are all 0.
- R2: From the second clock edge after the internal reset releases, `tx_n_o` is the complement of `tx_p_o` in every cycle.
- R3: Each subframe begins with an 8-half-cell preamble. The patterns, given first half first, are 11101000 for the left subframe of frame 0 of a block, 11100010 for every other left subframe, and 11100100 for every right subframe. The whole pattern is inverted when the line level just before it is 1.
- R4: Slots 4 to 31 are biphase-mark coded. Every cell starts with a level change, and a 1 adds a second change between the two half-cells.
- R5: Slots 4 to 27 carry the audio sample with bit 0 in slot 4 and bit 23 in slot 27. Slot 28 carries V (`vuc_*_i[2]`), slot 29 carries U (`vuc_*_i[1]`) and slot 30 carries C (`vuc_*_i[0]`).
- R6: Slot 31 is a parity bit that makes the count of ones in slots 4 to 31 even.
- R7: `len_i` gives the sample width. The `24 - len` lowest audio bits are sent as 0. A value below 16 acts as 16, and a value above 24 acts as 24.
- R8: `block_o` is 1 during frames 0 to 119 of each 192-frame block and 0 during frames 120 to 191. It changes only at the first half-cell of a frame.
- R9: `frame_sync_o` is 1 only during the first half-cell of each frame, once every 128 cycles. The inputs present at the clock edge that raises it are the ones sent in that frame.
- R10: Reset clears the half-cell and frame counters. The first frame after reset is frame 0 of a block, so it carries the block-start preamble and `block_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock, 128 times the sample rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| left_i | input | 24 | Left sample, left-justified |
| right_i | input | 24 | Right sample, left-justified |
| len_i | input | 5 | Sample width in bits (16 to 24) |
| vuc_l_i | input | 3 | Left V, U, C bits as [2]=V, [1]=U, [0]=C |
| vuc_r_i | input | 3 | Right V, U, C bits, same layout |
| tx_p_o | output | 1 | Line output, true phase |
| tx_n_o | output | 1 | Line output, inverted phase |
| block_o | output | 1 | High for frames 0 to 119 of the block |
| frame_sync_o | output | 1 | High during a frame's first half-cell |

## Verification
All outputs come from one register stage after the half-cell counter. The half-cell that `tx_p_o` shows in a given cycle therefore matches the `frame_sync_o` and `block_o` of that same cycle. The inputs take effect at the edge that raises `frame_sync_o`. The bench sets each vector after the last half-cell of the previous frame, at a falling edge, and waits for the rising edge. It then samples the 128 half-cells at the falling edges that follow. The expected stream is built from the level sampled one cycle before the frame. The reset checks sample one falling edge after reset is asserted. The first frame after release is compared against the block-start layout.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  localparam int AUDIO_W   = 24;
  localparam int WORD_W    = AUDIO_W + 3;
  localparam int SLOTS     = 32;
  localparam int HALVES    = 2 * 2 * SLOTS;
  localparam int CNT_W     = $clog2(HALVES);
  localparam int LEN_W     = $clog2(AUDIO_W + 1);
  localparam int PRE_SLOTS = 4;

  typedef logic [WORD_W-1:0] sub_word_t;

  // preamble half-cell patterns, MSB sent first, for a preceding level of 0
  localparam logic [7:0] PRE_BLOCK = 8'b1110_1000;
  localparam logic [7:0] PRE_LEFT  = 8'b1110_0010;
  localparam logic [7:0] PRE_RIGHT = 8'b1110_0100;
endpackage

// File: rtl/bmc_rst_sync.sv
module bmc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/bmc_timebase.sv
module bmc_timebase
  import bmc_pkg::*;
#(
  parameter int FRAMES = 192,
  localparam int FRM_W = $clog2(FRAMES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic [FRM_W-1:0] frm_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALVES - 1);
  localparam logic [FRM_W-1:0] FRM_LAST = FRM_W'(FRAMES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [FRM_W-1:0] frm_q, frm_d;
  logic             tick_en;

  assign tick_en = 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    frm_d = frm_q;
    if (tick_en) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) begin
        frm_d = (frm_q == FRM_LAST) ? '0 : frm_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      frm_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      frm_q <= frm_d;
    end
  end

  assign cnt_o = cnt_q;
  assign frm_o = frm_q;
endmodule

// File: rtl/bmc_subframe_builder.sv
module bmc_subframe_builder
  import bmc_pkg::*;
#(
  parameter int MIN_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic               first_frame_i,
  input  logic [AUDIO_W-1:0] left_i,
  input  logic [AUDIO_W-1:0] right_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [2:0]         vuc_l_i,
  input  logic [2:0]         vuc_r_i,
  output logic               bit_o,
  output logic [7:0]         pre_o
);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_W);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(AUDIO_W);

  logic [LEN_W-1:0]   eff_len;
  logic [AUDIO_W-1:0] keep_mask;
  sub_word_t          lw_q, lw_d, rw_q, rw_d, cur_word;
  logic [4:0]         slot, idx;
  logic               load_en;

  always_comb begin
    if (len_i < LEN_MIN)      eff_len = LEN_MIN;
    else if (len_i > LEN_MAX) eff_len = LEN_MAX;
    else                      eff_len = len_i;
  end

  always_comb begin
    for (int i = 0; i < AUDIO_W; i++) begin
      keep_mask[i] = (i >= (AUDIO_W - int'(eff_len)));
    end
  end

  assign load_en = (cnt_i == '0);

  always_comb begin
    lw_d = lw_q;
    rw_d = rw_q;
    if (load_en) begin
      lw_d = {vuc_l_i[0], vuc_l_i[1], vuc_l_i[2], left_i & keep_mask};
      rw_d = {vuc_r_i[0], vuc_r_i[1], vuc_r_i[2], right_i & keep_mask};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lw_q <= '0;
      rw_q <= '0;
    end else begin
      lw_q <= lw_d;
      rw_q <= rw_d;
    end
  end

  assign cur_word = cnt_i[CNT_W-1] ? rw_q : lw_q;
  assign slot     = cnt_i[5:1];
  assign idx      = slot - 5'd4;

  always_comb begin
    if (slot == 5'(SLOTS - 1))       bit_o = ^cur_word;
    else if (slot >= 5'(PRE_SLOTS))  bit_o = cur_word[idx];
    else                             bit_o = 1'b0;
  end

  always_comb begin
    if (cnt_i[CNT_W-1])     pre_o = PRE_RIGHT;
    else if (first_frame_i) pre_o = PRE_BLOCK;
    else                    pre_o = PRE_LEFT;
  end
endmodule

// File: rtl/bmc_line_coder.sv
module bmc_line_coder (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [5:0] pos_i,
  input  logic       bit_i,
  input  logic [7:0] pre_i,
  output logic       tx_p_o,
  output logic       tx_n_o
);
  logic txp_q, txn_q, pol_q;
  logic pol, line_d;

  always_comb begin
    pol = (pos_i == 6'd0) ? txp_q : pol_q;
    if (pos_i[5:3] == 3'd0) begin
      line_d = pre_i[3'd7 - pos_i[2:0]] ^ pol;
    end else if (!pos_i[0]) begin
      line_d = ~txp_q;
    end else begin
      line_d = bit_i ? ~txp_q : txp_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txp_q <= 1'b0;
      txn_q <= 1'b0;
      pol_q <= 1'b0;
    end else begin
      txp_q <= line_d;
      txn_q <= ~line_d;
      pol_q <= pol;
    end
  end

  assign tx_p_o = txp_q;
  assign tx_n_o = txn_q;
endmodule

// File: rtl/bmc_frame_encoder.sv
module bmc_frame_encoder
  import bmc_pkg::*;
#(
  parameter int MIN_W        = 16,
  parameter int FRAMES       = 192,
  parameter int BLOCK_FRAMES = 120,
  localparam int FRM_W       = $clog2(FRAMES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AUDIO_W-1:0] left_i,
  input  logic [AUDIO_W-1:0] right_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [2:0]         vuc_l_i,
  input  logic [2:0]         vuc_r_i,
  output logic               tx_p_o,
  output logic               tx_n_o,
  output logic               block_o,
  output logic               frame_sync_o
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] cnt_q;
  logic [FRM_W-1:0] frm_q;
  logic             data_bit;
  logic [7:0]       pre_pat;
  logic             sync_q, sync_d, block_q, block_d;

  bmc_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  bmc_timebase #(.FRAMES(FRAMES)) u_time (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .cnt_o  (cnt_q),
    .frm_o  (frm_q)
  );

  bmc_subframe_builder #(.MIN_W(MIN_W)) u_build (
    .clk_i         (clk_i),
    .rst_ni        (rst_sync_n),
    .cnt_i         (cnt_q),
    .first_frame_i (frm_q == '0),
    .left_i        (left_i),
    .right_i       (right_i),
    .len_i         (len_i),
    .vuc_l_i       (vuc_l_i),
    .vuc_r_i       (vuc_r_i),
    .bit_o         (data_bit),
    .pre_o         (pre_pat)
  );

  bmc_line_coder u_coder (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .pos_i  (cnt_q[5:0]),
    .bit_i  (data_bit),
    .pre_i  (pre_pat),
    .tx_p_o (tx_p_o),
    .tx_n_o (tx_n_o)
  );

  always_comb begin
    sync_d  = (cnt_q == '0);
    block_d = (frm_q < FRM_W'(BLOCK_FRAMES));
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sync_q  <= 1'b0;
      block_q <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      block_q <= block_d;
    end
  end

  assign frame_sync_o = sync_q;
  assign block_o      = block_q;
endmodule

// File: rtl/bmc_frame_encoder_chk.sv
module bmc_frame_encoder_chk (
  input logic       clk_i,
  input logic       rst_sync_n,
  input logic [5:0] pos,
  input logic       tx_p,
  input logic       tx_n,
  input logic       block,
  input logic       fsync
);
  logic live_q;

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) live_q <= 1'b0;
    else             live_q <= 1'b1;
  end

  AST_IDLE_LOW: assert property (@(posedge clk_i)
    !rst_sync_n |-> (!tx_p && !tx_n && !block && !fsync)); // R1

  AST_PAIR_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    live_q |-> (tx_n == !tx_p)); // R2

  AST_CELL_EDGE: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (live_q && !pos[0] && pos[5:3] != 3'd0) |=> (tx_p != $past(tx_p))); // R4

  AST_BLOCK_ON_SYNC: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ($rose(block) || $fell(block)) |-> fsync); // R8

  AST_SYNC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    fsync |=> !fsync); // R9
endmodule

bind bmc_frame_encoder bmc_frame_encoder_chk u_chk (
  .clk_i      (clk_i),
  .rst_sync_n (rst_sync_n),
  .pos        (cnt_q[5:0]),
  .tx_p       (tx_p_o),
  .tx_n       (tx_n_o),
  .block      (block_o),
  .fsync      (frame_sync_o)
);

// File: tb/bmc_frame_encoder_test.sv
`timescale 1ns/1ps
module bmc_frame_encoder_test;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [23:0] left_i, right_i;
  logic [4:0]  len_i;
  logic [2:0]  vuc_l_i, vuc_r_i;
  logic        tx_p_o, tx_n_o, block_o, frame_sync_o;

  int checks = 0;
  int errors = 0;
  int fidx   = 0;
  logic [127:0] exp_v, got_v;

  always #2.5 clk_i = ~clk_i;

  bmc_frame_encoder uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .left_i(left_i), .right_i(right_i),
    .len_i(len_i), .vuc_l_i(vuc_l_i), .vuc_r_i(vuc_r_i),
    .tx_p_o(tx_p_o), .tx_n_o(tx_n_o), .block_o(block_o),
    .frame_sync_o(frame_sync_o)
  );

  // {left, right, len, vuc_l, vuc_r}
  localparam logic [58:0] VEC [8] = '{
    {24'h000000, 24'h000000, 5'd24, 3'b000, 3'b000},
    {24'hFFFFFF, 24'hFFFFFF, 5'd24, 3'b111, 3'b111},
    {24'h123456, 24'hABCDEF, 5'd24, 3'b100, 3'b001},
    {24'h800001, 24'h7FFFFE, 5'd24, 3'b010, 3'b101},
    {24'hF0F0F5, 24'h0F0F0A, 5'd16, 3'b000, 3'b000},
    {24'h123457, 24'h89ABCD, 5'd20, 3'b001, 3'b110},
    {24'hA5A5A5, 24'h5A5A5A, 5'd10, 3'b100, 3'b100},
    {24'h0000FF, 24'hFF0000, 5'd31, 3'b111, 3'b000}
  };

  function automatic logic [23:0] width_mask(input logic [4:0] len);
    int n;
    n = (len < 16) ? 16 : (len > 24) ? 24 : int'(len);
    return 24'hFFFFFF << (24 - n);
  endfunction

  task automatic push_sub(inout int k, inout logic lvl, input logic [7:0] pre,
                          input logic [26:0] w);
    logic pol, h0, b;
    pol = lvl;
    for (int j = 0; j < 8; j++) begin
      exp_v[k] = pre[7-j] ^ pol;
      k++;
    end
    lvl = exp_v[k-1];
    for (int s = 4; s < 32; s++) begin
      b  = (s == 31) ? ^w : w[s-4];
      h0 = ~lvl;
      exp_v[k]   = h0;
      exp_v[k+1] = b ? ~h0 : h0;
      lvl = exp_v[k+1];
      k += 2;
    end
  endtask

  task automatic build_frame(input logic pol, input logic [58:0] v, input logic first);
    int k;
    logic lvl;
    logic [23:0] m;
    k   = 0;
    lvl = pol;
    m   = width_mask(v[10:6]);
    push_sub(k, lvl, first ? 8'b11101000 : 8'b11100010,
             {v[3], v[4], v[5], v[58:35] & m});
    push_sub(k, lvl, 8'b11100100, {v[0], v[1], v[2], v[34:11] & m});
  endtask

  task automatic check(input logic ok, input string what, input logic [127:0] got,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h exp %h", what, got, exp);
    end
  endtask

  task automatic run_frame(input int vi);
    logic [58:0] v;
    logic p, pair_ok, sync_ok, blk;
    int n;
    v = VEC[vi];
    {left_i, right_i, len_i, vuc_l_i, vuc_r_i} = v;
    n = 0;
    do begin
      p = tx_p_o;
      @(negedge clk_i);
      n++;
    end while (!frame_sync_o && n < 400);
    check(n < 400, "R9 frame sync not seen", 128'(n), 128'd0);
    blk = block_o;
    pair_ok = 1'b1;
    sync_ok = 1'b1;
    for (int k = 0; k < 128; k++) begin
      if (k > 0) begin
        @(negedge clk_i);
        if (frame_sync_o) sync_ok = 1'b0;
      end
      got_v[k] = tx_p_o;
      if (tx_n_o !== ~tx_p_o) pair_ok = 1'b0;
    end
    build_frame(p, v, (fidx % 192) == 0);
    // R3 R4 R5 R6 R7: whole frame stream, bit k = half-cell k
    check(got_v === exp_v, $sformatf("R3/R4/R5/R6/R7 frame %0d vec %0d stream", fidx, vi),
          got_v, exp_v);
    check(pair_ok, $sformatf("R2 frame %0d complement", fidx), 128'(pair_ok), 128'd1);
    check(sync_ok, $sformatf("R9 frame %0d extra sync", fidx), 128'(sync_ok), 128'd1);
    check(blk === ((fidx % 192) < 120), $sformatf("R8 frame %0d block", fidx),
          128'(blk), 128'((fidx % 192) < 120));
    fidx++;
  endtask

  initial begin
    #750000;
    checks++;
    errors++;
    $display("FAIL watchdog expired got timeout exp done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b1;
    {left_i, right_i, len_i, vuc_l_i, vuc_r_i} = VEC[0];
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check(!tx_p_o && !tx_n_o && !block_o && !frame_sync_o, "R1 reset outputs",
          128'({tx_p_o, tx_n_o, block_o, frame_sync_o}), 128'd0);
    rst_ni = 1'b1;

    // table walk: covers two block starts (frames 0 and 192) and 120-frame edge
    for (int f = 0; f < 200; f++) run_frame(f % 8);

    // reset in mid-frame
    repeat (40) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(!tx_p_o && !tx_n_o && !block_o && !frame_sync_o, "R1 mid-frame reset",
          128'({tx_p_o, tx_n_o, block_o, frame_sync_o}), 128'd0);
    repeat (3) @(negedge clk_i);
    check(!tx_p_o && !tx_n_o, "R1 reset held", 128'({tx_p_o, tx_n_o}), 128'd0);
    rst_ni = 1'b1;
    fidx = 0;
    // R10: counters restart, block-start preamble and block high
    run_frame(2);
    run_frame(5);
    check(fidx == 2, "R10 frame count", 128'(fidx), 128'd2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule